// File: doc/BRIEF.md
# Six-Channel Countdown Timer Bank

This block holds six independent down-counters behind a small register port. Software sets a reload interval for a channel, then writes that channel's control word to load the counter and start it. The counter steps down once on each cycle in which the external `tick_en` strobe is high. When a running channel expires, its sticky status bit is set and its own interrupt line pulses high for one clock.

A channel runs in one of two modes. In periodic mode it reloads from its interval on expiry and keeps counting. In single-shot mode it parks at zero and clears its own run bit. Status bits stay set until software writes a one to them. Reads are combinational from the address, and writes take effect at the next clock edge.

Top module: `cdt_timer_bank`

## Requirements
- R1: There are six channels, each with its own `irq_o` bit. The shared interrupt-enable register is at 0x00 and the status register is at 0x04. Channel n (0..5) occupies the window at 0x10*(n+1): control at +0x0, interval at +0x4 and live count at +0x8.
- R2: Writing a channel's interval register stores the value the counter restarts from, and a read returns that value.
- R3: A control write with the reload bit (bit 1) set copies the interval into the count in that same write.
- R4: Control bit 0 (run) set makes the count drop by one on each `tick_en` cycle. With run clear, the count holds its value.
- R5: When a running channel sees `tick_en` while its count is 0 or 1, it expires. Its status bit is set and its `irq_o` bit is high for exactly the next cycle, whatever the enable register holds.
- R6: When control bit 2 is clear (periodic mode), expiry reloads the count from the interval, so the channel fires once every interval ticks.
- R7: When control bit 2 is set (single-shot mode), expiry sets the count to 0 and the hardware clears that channel's run bit.
- R8: Writing the status register clears each bit written as one and leaves bits written as zero unchanged. An expiry in the same cycle as the write leaves its bit set.
- R9: The interrupt-enable register is a plain read/write register of six bits. Reads of a count register return the live counter value.
- R10: Reset stops every channel and clears the enable register, the status register, the intervals and the counts. It loads every control register with 0x10, which is the clock-select field (bits 6:4) set to 001.
- R11: Reads of unmapped offsets return zero, and writes to them are ignored. Writes to a count register are also ignored. A control write takes priority over a tick in the same cycle for that channel.
- R12: Control bits other than 0, 1, 2 and 6:4 read back as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count-step strobe shared by all channels |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| irq_o | output | 6 | One-cycle expiry pulse per channel |

## Verification
The assertions check several properties on every cycle. Every interrupt pulse has its status bit set and follows a tick. A status write clears the written bits unless an expiry sets them again. Counts never move without a tick or a write. Single-shot channels have dropped their run bit by the time they pulse. Reset leaves the enable and status registers empty. The exact count sequence, the periodic reload period, the reload-on-write path, the ignored writes and the priority of a control write over a tick can only be shown by the bench's scenarios, which compare against a reference model on every clock.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    // offsets inside a channel window
    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_INTV = 4'h4;
    localparam logic [3:0] OFS_CNT  = 4'h8;
    // offsets inside the shared window
    localparam logic [3:0] OFS_IEN  = 4'h0;
    localparam logic [3:0] OFS_STS  = 4'h4;

    typedef struct packed {
        logic [2:0] clk_sel;
        logic       single_shot;
        logic       reload;
        logic       run;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{clk_sel: 3'b001, single_shot: 1'b0,
                                   reload: 1'b0, run: 1'b0};

    typedef enum logic [2:0] {
        TGT_NONE, TGT_IEN, TGT_STS, TGT_CTRL, TGT_INTV, TGT_CNT
    } tgt_e;

    typedef struct packed {
        tgt_e       tgt;
        logic [3:0] ch;
    } dec_t;

    function automatic ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.run         = w[0];
        c.reload      = w[1];
        c.single_shot = w[2];
        c.clk_sel     = w[6:4];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w      = '0;
        w[0]   = c.run;
        w[1]   = c.reload;
        w[2]   = c.single_shot;
        w[6:4] = c.clk_sel;
        return w;
    endfunction

endpackage

// File: rtl/cdt_decode.sv
module cdt_decode
    import cdt_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    logic [3:0] bank;
    logic [3:0] ofs;

    assign bank = addr[7:4];
    assign ofs  = addr[3:0];

    always_comb begin
        dec.tgt = TGT_NONE;
        dec.ch  = '0;
        if (bank == 4'd0) begin
            if (ofs == OFS_IEN)
                dec.tgt = TGT_IEN;
            else if (ofs == OFS_STS)
                dec.tgt = TGT_STS;
        end else if (bank <= 4'(NUM_CH)) begin
            dec.ch = bank - 4'd1;
            case (ofs)
                OFS_CTRL: dec.tgt = TGT_CTRL;
                OFS_INTV: dec.tgt = TGT_INTV;
                OFS_CNT:  dec.tgt = TGT_CNT;
                default:  dec.tgt = TGT_NONE;
            endcase
        end
    end
endmodule

// File: rtl/cdt_channel.sv
module cdt_channel
    import cdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             ctrl_we,
    input  ctrl_t            ctrl_wr,
    input  logic             intv_we,
    input  logic [CNT_W-1:0] intv_wr,
    output ctrl_t            ctrl_q,
    output logic [CNT_W-1:0] intv_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);
    logic at_end;
    logic stepping;

    assign at_end   = (cnt_q <= CNT_W'(1));
    assign stepping = ctrl_q.run && tick_en && !ctrl_we;
    assign expire   = stepping && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
            intv_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (intv_we)
                intv_q <= intv_wr;
            if (ctrl_we) begin
                ctrl_q <= ctrl_wr;
                if (ctrl_wr.reload)
                    cnt_q <= intv_q;
            end else if (stepping) begin
                if (at_end) begin
                    if (ctrl_q.single_shot) begin
                        cnt_q      <= '0;
                        ctrl_q.run <= 1'b0;
                    end else begin
                        cnt_q <= intv_q;
                    end
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/cdt_irq_ctrl.sv
module cdt_irq_ctrl #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ien_we,
    input  logic              sts_we,
    input  logic [NUM_CH-1:0] wr_bits,
    input  logic [NUM_CH-1:0] expire,
    output logic [NUM_CH-1:0] ien_q,
    output logic [NUM_CH-1:0] sts_q,
    output logic [NUM_CH-1:0] pulse_q
);
    logic [NUM_CH-1:0] clr_mask;

    assign clr_mask = sts_we ? wr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q   <= '0;
            sts_q   <= '0;
            pulse_q <= '0;
        end else begin
            if (ien_we)
                ien_q <= wr_bits;
            sts_q   <= (sts_q & ~clr_mask) | expire;
            pulse_q <= expire;
        end
    end
endmodule

// File: rtl/cdt_timer_bank.sv
module cdt_timer_bank
    import cdt_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_CH-1:0] irq_o
);
    dec_t                    dec;
    logic [NUM_CH-1:0]       expire;
    logic [NUM_CH-1:0]       irq_en_q;
    logic [NUM_CH-1:0]       irq_sts_q;
    logic [NUM_CH-1:0]       run_vec;
    logic [NUM_CH-1:0]       ss_vec;
    logic [NUM_CH*CNT_W-1:0] cnt_flat;
    logic [DATA_W-1:0]       ch_rd [NUM_CH];
    ctrl_t                   ctrl_wr;

    assign ctrl_wr = ctrl_from_word(wdata);

    cdt_decode #(.NUM_CH(NUM_CH)) dec_i (
        .addr (addr),
        .dec  (dec)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic        sel;
        logic        c_we;
        logic        i_we;
        ctrl_t       c_q;
        logic [CNT_W-1:0] iv_q;
        logic [CNT_W-1:0] ct_q;

        assign sel  = (dec.ch == 4'(i));
        assign c_we = wr_en && sel && (dec.tgt == TGT_CTRL);
        assign i_we = wr_en && sel && (dec.tgt == TGT_INTV);

        cdt_channel #(.CNT_W(CNT_W)) chan_i (
            .clk     (clk),
            .rst     (rst),
            .tick_en (tick_en),
            .ctrl_we (c_we),
            .ctrl_wr (ctrl_wr),
            .intv_we (i_we),
            .intv_wr (wdata[CNT_W-1:0]),
            .ctrl_q  (c_q),
            .intv_q  (iv_q),
            .cnt_q   (ct_q),
            .expire  (expire[i])
        );

        assign run_vec[i] = c_q.run;
        assign ss_vec[i]  = c_q.single_shot;
        assign cnt_flat[i*CNT_W +: CNT_W] = ct_q;

        always_comb begin
            ch_rd[i] = '0;
            if (sel) begin
                case (dec.tgt)
                    TGT_CTRL: ch_rd[i] = ctrl_to_word(c_q);
                    TGT_INTV: ch_rd[i] = DATA_W'(iv_q);
                    TGT_CNT:  ch_rd[i] = DATA_W'(ct_q);
                    default:  ch_rd[i] = '0;
                endcase
            end
        end
    end

    cdt_irq_ctrl #(.NUM_CH(NUM_CH)) irq_i (
        .clk     (clk),
        .rst     (rst),
        .ien_we  (wr_en && dec.tgt == TGT_IEN),
        .sts_we  (wr_en && dec.tgt == TGT_STS),
        .wr_bits (wdata[NUM_CH-1:0]),
        .expire  (expire),
        .ien_q   (irq_en_q),
        .sts_q   (irq_sts_q),
        .pulse_q (irq_o)
    );

    always_comb begin
        rd_data = '0;
        case (dec.tgt)
            TGT_IEN: rd_data = DATA_W'(irq_en_q);
            TGT_STS: rd_data = DATA_W'(irq_sts_q);
            default: begin
                for (int k = 0; k < NUM_CH; k++)
                    rd_data = rd_data | ch_rd[k];
            end
        endcase
    end
endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    tick_en,
    input logic                    wr_en,
    input logic [7:0]              addr,
    input logic [31:0]             wdata,
    input logic [NUM_CH-1:0]       irq_o,
    input logic [NUM_CH-1:0]       irq_en_q,
    input logic [NUM_CH-1:0]       irq_sts_q,
    input logic [NUM_CH-1:0]       run_vec,
    input logic [NUM_CH-1:0]       ss_vec,
    input logic [NUM_CH*CNT_W-1:0] cnt_flat
);
    logic sts_write;
    assign sts_write = wr_en && (addr == 8'h04);

    // R5: every pulse is backed by a set status bit
    assert_pulse_sets_status_R5: assert property (@(posedge clk) disable iff (rst)
        (irq_o & ~irq_sts_q) == '0);

    // R5: a pulse only follows a tick cycle
    assert_pulse_after_tick_R5: assert property (@(posedge clk) disable iff (rst)
        (|irq_o) |-> $past(tick_en));

    // R8: written ones are cleared unless a new expiry sets them
    assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (rst)
        $past(sts_write) |-> ((irq_sts_q & $past(wdata[NUM_CH-1:0]) & ~irq_o) == '0));

    // R4: counts never move without a tick or a write
    assert_hold_without_tick_R4: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !wr_en) |=> $stable(cnt_flat));

    // R10: reset empties enable and status
    assert_reset_clears_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_en_q == '0 && irq_sts_q == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R7: single-shot channels have stopped when they pulse
        assert_oneshot_stops_R7: assert property (@(posedge clk) disable iff (rst)
            (irq_o[i] && ss_vec[i]) |-> !run_vec[i]);
    end
endmodule

bind cdt_timer_bank cdt_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .irq_o     (irq_o),
    .irq_en_q  (irq_en_q),
    .irq_sts_q (irq_sts_q),
    .run_vec   (run_vec),
    .ss_vec    (ss_vec),
    .cnt_flat  (cnt_flat)
);

// File: tb/cdt_timer_bank_tb.sv
module cdt_timer_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_data;
    logic [5:0]  irq_o;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    logic [31:0] m_ctrl [6];
    logic [31:0] m_intv [6];
    logic [31:0] m_cnt  [6];
    logic [5:0]  m_ien, m_sts, m_irq;

    always #2 clk = ~clk;

    cdt_timer_bank dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 6; i++) begin
            m_ctrl[i] = 32'h10; m_intv[i] = 0; m_cnt[i] = 0;
        end
        m_ien = 0; m_sts = 0; m_irq = 0;
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        int b = a[7:4];
        int o = a[3:0];
        if (b == 0) begin
            if (o == 0) return {26'b0, m_ien};
            if (o == 4) return {26'b0, m_sts};
            return 0;
        end
        if (b > 6) return 0;
        if (o == 0) return m_ctrl[b-1];
        if (o == 4) return m_intv[b-1];
        if (o == 8) return m_cnt[b-1];
        return 0;
    endfunction

    task automatic model_step(input bit w, input logic [7:0] a, input logic [31:0] d, input bit t);
        logic [5:0] ex = 0;
        int b = a[7:4];
        int o = a[3:0];
        for (int i = 0; i < 6; i++) begin
            if (w && b == i + 1 && o == 0) begin
                m_ctrl[i] = d & 32'h77;
                if (d[1]) m_cnt[i] = m_intv[i];
            end else if (m_ctrl[i][0] && t) begin
                if (m_cnt[i] <= 1) begin
                    ex[i] = 1'b1;
                    if (m_ctrl[i][2]) begin
                        m_cnt[i] = 0;
                        m_ctrl[i][0] = 1'b0;
                    end else begin
                        m_cnt[i] = m_intv[i];
                    end
                end else begin
                    m_cnt[i] = m_cnt[i] - 1;
                end
            end
            if (w && b == i + 1 && o == 4) m_intv[i] = d;
        end
        if (w && b == 0 && o == 0) m_ien = d[5:0];
        if (w && b == 0 && o == 4) m_sts = m_sts & ~d[5:0];
        m_sts = m_sts | ex;
        m_irq = ex;
    endtask

    // one clock: drive, compare read, clock model, compare pulses
    task automatic step(input string tag, input bit w, input logic [7:0] a,
                        input logic [31:0] d, input bit t);
        wr_en = w; addr = a; wdata = d; tick_en = t;
        #1;
        check(tag, rd_data, model_read(a));
        @(posedge clk);
        model_step(w, a, d, t);
        @(negedge clk);
        check("R5 irq", {26'b0, irq_o}, {26'b0, m_irq});
    endtask

    task automatic do_reset();
        rst = 1'b1; wr_en = 0; tick_en = 0;
        repeat (2) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R10 reset values, R1 map
        step("R10", 0, 8'h00, 0, 0);
        step("R10", 0, 8'h04, 0, 0);
        for (int c = 1; c <= 6; c++) begin
            step("R10", 0, 8'(c * 16), 0, 0);
            step("R10", 0, 8'(c * 16 + 4), 0, 0);
            step("R10", 0, 8'(c * 16 + 8), 0, 0);
        end
        // R2 interval write/readback
        step("R2", 1, 8'h14, 32'd5, 0);
        step("R2", 0, 8'h14, 0, 0);
        // R3 reload on control write, R6 periodic
        step("R3", 1, 8'h10, 32'h13, 0);
        step("R3", 0, 8'h18, 0, 0);
        for (int k = 0; k < 14; k++) step("R6", 0, 8'h18, 0, 1);
        // R4 stop holds, restart without reload, sparse ticks
        step("R4", 1, 8'h10, 32'h10, 1);
        for (int k = 0; k < 5; k++) step("R4", 0, 8'h18, 0, 1);
        step("R4", 1, 8'h10, 32'h11, 0);
        for (int k = 0; k < 12; k++) step("R4", 0, 8'h18, 0, k[0]);
        step("R4", 1, 8'h10, 32'h10, 0);
        // R7 single shot on channel 1
        step("R7", 1, 8'h24, 32'd3, 0);
        step("R7", 1, 8'h20, 32'h07, 0);
        for (int k = 0; k < 6; k++) step("R7", 0, 8'h20, 0, 1);
        step("R7", 0, 8'h28, 0, 1);
        // R8 write-one-to-clear
        step("R8", 0, 8'h04, 0, 0);
        step("R8", 1, 8'h04, 32'h01, 0);
        step("R8", 0, 8'h04, 0, 0);
        step("R8", 1, 8'h04, 32'h3F, 0);
        step("R8", 0, 8'h04, 0, 0);
        // R8 set beats clear: channel 2 fires every tick
        step("R8", 1, 8'h34, 32'd1, 0);
        step("R8", 1, 8'h30, 32'h03, 0);
        step("R8", 1, 8'h04, 32'h3F, 1);
        step("R8", 0, 8'h04, 0, 0);
        step("R8", 1, 8'h04, 32'h04, 0);
        step("R8", 0, 8'h04, 0, 0);
        step("R8", 1, 8'h30, 32'h10, 0);
        // R9 enable register and live count
        step("R9", 1, 8'h00, 32'hFFFF_FFFF, 0);
        step("R9", 0, 8'h00, 0, 0);
        step("R9", 1, 8'h00, 32'h15, 0);
        step("R9", 0, 8'h00, 0, 0);
        // R11 ignored writes
        step("R11", 1, 8'h0C, 32'hAB, 0);
        step("R11", 1, 8'h7C, 32'hAB, 0);
        step("R11", 1, 8'h70, 32'hAB, 0);
        step("R11", 1, 8'h18, 32'hAB, 0);
        step("R11", 0, 8'h0C, 0, 0);
        step("R11", 0, 8'h70, 0, 0);
        step("R11", 0, 8'h1C, 0, 0);
        step("R11", 0, 8'h18, 0, 0);
        step("R11", 0, 8'h00, 0, 0);
        // R11 control write wins over a tick
        step("R11", 1, 8'h44, 32'd4, 0);
        step("R11", 1, 8'h40, 32'h03, 1);
        step("R11", 0, 8'h48, 0, 0);
        step("R11", 1, 8'h40, 32'h01, 1);
        step("R11", 0, 8'h48, 0, 1);
        step("R11", 1, 8'h40, 32'h10, 0);
        // R12 undefined control bits
        step("R12", 1, 8'h50, 32'hFFFF_FFF8, 0);
        step("R12", 0, 8'h50, 0, 0);
        step("R12", 1, 8'h50, 32'h10, 0);
        step("R12", 0, 8'h50, 0, 0);
        // R1 all six channels at once
        for (int c = 0; c < 6; c++) step("R1", 1, 8'(c * 16 + 20), 32'(c + 2), 0);
        for (int c = 0; c < 6; c++) step("R1", 1, 8'(c * 16 + 16), 32'h13, 0);
        for (int k = 0; k < 30; k++) begin
            step("R1", 0, 8'h04, 0, 1);
            step("R1", 1, 8'h04, 32'h3F, 0);
        end
        // R10 reset in the middle of activity
        do_reset();
        step("R10", 0, 8'h04, 0, 1);
        step("R10", 0, 8'h10, 0, 1);
        step("R10", 0, 8'h18, 0, 1);
        step("R10", 0, 8'h64, 0, 1);
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule